// File: doc/BRIEF.md
# Tagged Capability Register File

This block is a 32-entry general-purpose register file in which every entry carries a one-bit tag. A clear tag means the entry holds a plain 64-bit integer. A set tag means it holds an unpacked capability made of a type, permissions, a cursor, a base address and an end address. Two combinational read ports return the tag together with the payload, so a consumer can detect when an integer is used where a capability is expected, or the reverse. One synchronous write port carries ordinary results.

Alongside the write port sits a dedicated capability-move channel that keeps linear capabilities from aliasing. The move copies a capability from a source register to a destination register. When the capability is linear, the source register receives the null capability on the same clock edge. A non-linear capability stays in the source register as well. If the move names a source that does not hold a capability, it reports a trap in the same cycle and alters nothing. If source and destination are the same register, the move has no effect.

Register 0 is hardwired to integer zero by default, and writes to it are discarded.

Top module: `capreg_file`

## Requirements
- R1: After reset, every register reads back with a tag of 0 and an all-zero payload.
- R2: Register 0 always reads tag 0 with a zero payload. An ordinary write or a move aimed at it leaves that reading unchanged.
- R3: An ordinary write with tag 1 stores the full payload. An ordinary write with tag 0 stores only the low 64 bits of the payload and zeroes the bits above them. The result is visible on the read ports after the next rising edge.
- R4: `mv_trap` is high in the same cycle as a move request whose source register has tag 0. Such a move changes no register.
- R5: A move with source equal to destination raises no trap when the source is tagged and changes no register.
- R6: A move of a tagged entry whose type field is nonzero copies the entry to the destination and leaves the source unchanged. Type codes are 0 linear, 1 non-linear, 2 sealed and 3 uninitialised. The type field occupies the top two payload bits.
- R7: A move of a tagged entry whose type field is 0 copies the entry to the destination and, on the same edge, sets the source to the null capability. The null capability is tag 1 with an all-zero payload.
- R8: When an accepted move writes a register or clears a register that the ordinary write port also targets in the same cycle, the move's value is stored and the ordinary write is dropped.
- R9: An ordinary write to a register that the move does not touch still takes effect in the same cycle as the move, including when the move traps.
- R10: The two read ports select and return entries independently of each other, within the same cycle as their index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_a_idx | input | 5 | Read port A register index |
| rd_a_tag | output | 1 | Read port A tag (1 = capability) |
| rd_a_data | output | 197 | Read port A payload {type[1:0], perms[2:0], cursor[63:0], base[63:0], end[63:0]} |
| rd_b_idx | input | 5 | Read port B register index |
| rd_b_tag | output | 1 | Read port B tag |
| rd_b_data | output | 197 | Read port B payload |
| wr_en | input | 1 | Ordinary write enable |
| wr_idx | input | 5 | Ordinary write register index |
| wr_tag | input | 1 | Tag to store with the write |
| wr_data | input | 197 | Payload to store (low 64 bits only when the tag is 0) |
| mv_en | input | 1 | Capability move request |
| mv_src | input | 5 | Move source register index |
| mv_dst | input | 5 | Move destination register index |
| mv_trap | output | 1 | Move rejected: the source is not a capability |

## Verification
On every clock, assertions check three things: an accepted move lands in its destination on the next edge; a linear move leaves the null capability behind; and a trapped or self-targeted move asks the storage to write nothing. Assertions also check that an unobstructed ordinary write reaches its register. The bench's scenarios are needed for the rest. These cover the integer masking of upper bits, the hardwired zero register, and the read-port independence. They also cover how moves and writes resolve across long chains, where a linear capability travels through several registers and each hop must leave exactly one live copy. The random phase packs operations onto a dozen registers so that writes, clears and moves collide often.

// File: rtl/capreg_pkg.sv
package capreg_pkg;

   localparam int DEF_REGS   = 32;
   localparam int DEF_XLEN   = 64;
   localparam int DEF_PERM_W = 3;
   localparam int DEF_TYPE_W = 2;

   // capability type codes; the move logic only distinguishes linear
   typedef enum logic [1:0] {
      CT_LINEAR    = 2'd0,
      CT_NONLINEAR = 2'd1,
      CT_SEALED    = 2'd2,
      CT_UNINIT    = 2'd3
   } cap_type_e;

   function automatic int payload_width(int xlen, int perm_w, int type_w);
      return 3 * xlen + perm_w + type_w;
   endfunction

endpackage

// File: rtl/capreg_read_mux.sv
module capreg_read_mux #(
   parameter int REGS  = 32,
   parameter int IDX_W = 5,
   parameter int ENT_W = 198
) (
   input  logic [ENT_W-1:0] regs_i [REGS],
   input  logic [IDX_W-1:0] idx_i,
   output logic [ENT_W-1:0] ent_o
);

   localparam int SPAN = 1 << IDX_W;

   generate
      if (SPAN == REGS) begin : g_full
         assign ent_o = regs_i[idx_i];
      end else begin : g_partial
         // indices past the last register read as integer zero
         assign ent_o = (int'(idx_i) < REGS) ? regs_i[idx_i] : '0;
      end
   endgenerate

endmodule

// File: rtl/capreg_move_ctrl.sv
module capreg_move_ctrl
   import capreg_pkg::*;
#(
   parameter int IDX_W  = 5,
   parameter int PAY_W  = 197,
   parameter int TYPE_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mv_en_i,
   input  logic [IDX_W-1:0] src_i,
   input  logic [IDX_W-1:0] dst_i,
   input  logic [PAY_W:0]   src_ent_i,
   output logic             trap_o,
   output logic             wr_en_o,
   output logic [IDX_W-1:0] wr_idx_o,
   output logic [PAY_W:0]   wr_ent_o,
   output logic             clr_en_o,
   output logic [IDX_W-1:0] clr_idx_o
);

   logic              src_is_cap;
   logic              distinct;
   logic              accept;
   logic [TYPE_W-1:0] src_type;

   assign src_is_cap = src_ent_i[PAY_W];
   assign src_type   = src_ent_i[PAY_W-1 -: TYPE_W];
   assign distinct   = (src_i != dst_i);

   assign trap_o   = mv_en_i && !src_is_cap;
   assign accept   = mv_en_i && src_is_cap && distinct;

   assign wr_en_o  = accept;
   assign wr_idx_o = dst_i;
   assign wr_ent_o = src_ent_i;

   // a linear capability must not survive in two places
   assign clr_en_o  = accept && (src_type == TYPE_W'(CT_LINEAR));
   assign clr_idx_o = src_i;

   a_r4_trap_blocks_update: assert property (@(posedge clk) disable iff (!rst_n)
      trap_o |-> (!wr_en_o && !clr_en_o));

   a_r5_self_move_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (mv_en_i && (src_i == dst_i)) |-> (!wr_en_o && !clr_en_o));

   a_r6_nonlinear_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_o && (wr_ent_o[PAY_W-1 -: TYPE_W] != '0)) |-> !clr_en_o);

endmodule

// File: rtl/capreg_array.sv
module capreg_array #(
   parameter int REGS     = 32,
   parameter int IDX_W    = 5,
   parameter int XLEN     = 64,
   parameter int PAY_W    = 197,
   parameter int NRD      = 3,
   parameter bit ZERO_REG = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NRD*IDX_W-1:0]   rd_idx_i,
   output logic [NRD*(PAY_W+1)-1:0] rd_ent_o,
   input  logic                   wr_en_i,
   input  logic [IDX_W-1:0]       wr_idx_i,
   input  logic [PAY_W:0]         wr_ent_i,
   input  logic                   mv_en_i,
   input  logic [IDX_W-1:0]       mv_idx_i,
   input  logic [PAY_W:0]         mv_ent_i,
   input  logic                   clr_en_i,
   input  logic [IDX_W-1:0]       clr_idx_i
);

   localparam int ENT_W = PAY_W + 1;
   localparam logic [ENT_W-1:0] NULL_CAP = {1'b1, {PAY_W{1'b0}}};

   logic [ENT_W-1:0] regs [REGS];
   logic [ENT_W-1:0] wr_masked;

   // integers keep only their low XLEN bits
   assign wr_masked = wr_ent_i[PAY_W] ? wr_ent_i
                                      : {1'b0, {(PAY_W-XLEN){1'b0}}, wr_ent_i[XLEN-1:0]};

   generate
      for (genvar i = 0; i < REGS; i++) begin : g_ent
         if (ZERO_REG && i == 0) begin : g_zero
            assign regs[i] = '0;
         end else begin : g_reg
            logic             hit_mv, hit_clr, hit_wr;
            logic [ENT_W-1:0] q;
            assign hit_mv  = mv_en_i  && (mv_idx_i  == IDX_W'(i));
            assign hit_clr = clr_en_i && (clr_idx_i == IDX_W'(i));
            assign hit_wr  = wr_en_i  && (wr_idx_i  == IDX_W'(i));
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)       q <= '0;
               else if (hit_mv)  q <= mv_ent_i;
               else if (hit_clr) q <= NULL_CAP;
               else if (hit_wr)  q <= wr_masked;
            end
            assign regs[i] = q;
         end
      end

      for (genvar p = 0; p < NRD; p++) begin : g_rd
         capreg_read_mux #(
            .REGS  (REGS),
            .IDX_W (IDX_W),
            .ENT_W (ENT_W)
         ) i_mux (
            .regs_i (regs),
            .idx_i  (rd_idx_i[p*IDX_W +: IDX_W]),
            .ent_o  (rd_ent_o[p*ENT_W +: ENT_W])
         );
      end
   endgenerate

   a_r3_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && (wr_idx_i != '0) && (int'(wr_idx_i) < REGS)
       && !(mv_en_i && mv_idx_i == wr_idx_i) && !(clr_en_i && clr_idx_i == wr_idx_i))
      |=> (regs[$past(wr_idx_i)] == $past(wr_masked)));

   a_r8_move_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (mv_en_i && (mv_idx_i != '0) && (int'(mv_idx_i) < REGS))
      |=> (regs[$past(mv_idx_i)] == $past(mv_ent_i)));

   a_r7_source_nulled: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_en_i && (clr_idx_i != '0) && (int'(clr_idx_i) < REGS)
       && !(mv_en_i && mv_idx_i == clr_idx_i))
      |=> (regs[$past(clr_idx_i)] == NULL_CAP));

endmodule

// File: rtl/capreg_file.sv
module capreg_file
   import capreg_pkg::*;
#(
   parameter int REGS     = DEF_REGS,
   parameter int XLEN     = DEF_XLEN,
   parameter int PERM_W   = DEF_PERM_W,
   parameter int TYPE_W   = DEF_TYPE_W,
   parameter bit ZERO_REG = 1'b1,
   localparam int IDX_W   = $clog2(REGS),
   localparam int PAY_W   = 3 * XLEN + PERM_W + TYPE_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_a_idx,
   output logic             rd_a_tag,
   output logic [PAY_W-1:0] rd_a_data,
   input  logic [IDX_W-1:0] rd_b_idx,
   output logic             rd_b_tag,
   output logic [PAY_W-1:0] rd_b_data,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic             wr_tag,
   input  logic [PAY_W-1:0] wr_data,
   input  logic             mv_en,
   input  logic [IDX_W-1:0] mv_src,
   input  logic [IDX_W-1:0] mv_dst,
   output logic             mv_trap
);

   localparam int ENT_W = PAY_W + 1;
   localparam int NRD   = 3;

   generate
      if (REGS < 2) begin : g_bad_regs
         $error("capreg_file: REGS must be at least 2");
      end
      if (TYPE_W < 2) begin : g_bad_type
         $error("capreg_file: TYPE_W must hold four type codes");
      end
      if (PAY_W != payload_width(XLEN, PERM_W, TYPE_W)) begin : g_bad_pay
         $error("capreg_file: payload width mismatch");
      end
   endgenerate

   logic [NRD*IDX_W-1:0] rd_idx;
   logic [NRD*ENT_W-1:0] rd_ent;
   logic [ENT_W-1:0]     src_ent;
   logic                 mv_wr_en, clr_en;
   logic [IDX_W-1:0]     mv_wr_idx, clr_idx;
   logic [ENT_W-1:0]     mv_wr_ent;

   // port 2 feeds the move source
   assign rd_idx  = {mv_src, rd_b_idx, rd_a_idx};
   assign src_ent = rd_ent[2*ENT_W +: ENT_W];

   assign {rd_a_tag, rd_a_data} = rd_ent[0 +: ENT_W];
   assign {rd_b_tag, rd_b_data} = rd_ent[ENT_W +: ENT_W];

   capreg_move_ctrl #(
      .IDX_W  (IDX_W),
      .PAY_W  (PAY_W),
      .TYPE_W (TYPE_W)
   ) i_move (
      .clk       (clk),
      .rst_n     (rst_n),
      .mv_en_i   (mv_en),
      .src_i     (mv_src),
      .dst_i     (mv_dst),
      .src_ent_i (src_ent),
      .trap_o    (mv_trap),
      .wr_en_o   (mv_wr_en),
      .wr_idx_o  (mv_wr_idx),
      .wr_ent_o  (mv_wr_ent),
      .clr_en_o  (clr_en),
      .clr_idx_o (clr_idx)
   );

   capreg_array #(
      .REGS     (REGS),
      .IDX_W    (IDX_W),
      .XLEN     (XLEN),
      .PAY_W    (PAY_W),
      .NRD      (NRD),
      .ZERO_REG (ZERO_REG)
   ) i_array (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_idx_i  (rd_idx),
      .rd_ent_o  (rd_ent),
      .wr_en_i   (wr_en),
      .wr_idx_i  (wr_idx),
      .wr_ent_i  ({wr_tag, wr_data}),
      .mv_en_i   (mv_wr_en),
      .mv_idx_i  (mv_wr_idx),
      .mv_ent_i  (mv_wr_ent),
      .clr_en_i  (clr_en),
      .clr_idx_i (clr_idx)
   );

endmodule

// File: tb/test_capreg_file.sv
`timescale 1ns/1ps
module test_capreg_file;

   localparam int XLEN  = 64;
   localparam int PAY_W = 197;
   localparam int ENT_W = PAY_W + 1;
   localparam logic [ENT_W-1:0] NULL_E = {1'b1, {PAY_W{1'b0}}};

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [4:0]       rd_a_idx = '0, rd_b_idx = '0;
   logic             rd_a_tag, rd_b_tag;
   logic [PAY_W-1:0] rd_a_data, rd_b_data;
   logic             wr_en = 1'b0, wr_tag = 1'b0;
   logic [4:0]       wr_idx = '0;
   logic [PAY_W-1:0] wr_data = '0;
   logic             mv_en = 1'b0;
   logic [4:0]       mv_src = '0, mv_dst = '0;
   logic             mv_trap;

   int vectors = 0;
   int errors  = 0;
   logic [ENT_W-1:0] m [32];

   always #2.5 clk = ~clk;

   capreg_file i_capreg_file (
      .clk(clk), .rst_n(rst_n),
      .rd_a_idx(rd_a_idx), .rd_a_tag(rd_a_tag), .rd_a_data(rd_a_data),
      .rd_b_idx(rd_b_idx), .rd_b_tag(rd_b_tag), .rd_b_data(rd_b_data),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_data(wr_data),
      .mv_en(mv_en), .mv_src(mv_src), .mv_dst(mv_dst), .mv_trap(mv_trap)
   );

   function automatic logic [PAY_W-1:0] mkcap(logic [1:0] ty, logic [2:0] pm,
                                              logic [63:0] cur, logic [63:0] lo,
                                              logic [63:0] hi);
      return {ty, pm, cur, lo, hi};
   endfunction

   function automatic logic [PAY_W-1:0] rnd_pay();
      logic [223:0] r = {$urandom, $urandom, $urandom, $urandom,
                         $urandom, $urandom, $urandom};
      return r[PAY_W-1:0];
   endfunction

   function automatic logic [ENT_W-1:0] stored(logic t, logic [PAY_W-1:0] d);
      return t ? {1'b1, d} : {1'b0, {(PAY_W-XLEN){1'b0}}, d[XLEN-1:0]};
   endfunction

   task automatic check(string req, logic [ENT_W-1:0] act, logic [ENT_W-1:0] exp);
      vectors++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // one cycle: drive, check reads and trap against the model, advance model
   task automatic step(logic we, logic [4:0] wi, logic wt, logic [PAY_W-1:0] wd,
                       logic me, logic [4:0] ms, logic [4:0] md,
                       logic [4:0] ra, logic [4:0] rb, string req);
      logic acc, lin;
      logic [ENT_W-1:0] nm [32];
      @(negedge clk);
      wr_en = we; wr_idx = wi; wr_tag = wt; wr_data = wd;
      mv_en = me; mv_src = ms; mv_dst = md;
      rd_a_idx = ra; rd_b_idx = rb;
      #1;
      check({req, " port A"}, {rd_a_tag, rd_a_data}, m[ra]);
      check({req, " port B"}, {rd_b_tag, rd_b_data}, m[rb]);
      check({req, " trap"}, ENT_W'(mv_trap), ENT_W'(me && !m[ms][PAY_W]));
      nm  = m;
      acc = me && m[ms][PAY_W] && (ms != md);
      lin = acc && (m[ms][PAY_W-1 -: 2] == 2'd0);
      if (we && wi != 0 && !(acc && wi == md) && !(lin && wi == ms))
         nm[wi] = stored(wt, wd);
      if (acc && md != 0) nm[md] = m[ms];
      if (lin && ms != 0) nm[ms] = NULL_E;
      m = nm;
   endtask

   task automatic idle_read(logic [4:0] ra, logic [4:0] rb, string req);
      step(1'b0, 5'd0, 1'b0, '0, 1'b0, 5'd0, 5'd0, ra, rb, req);
   endtask

   initial begin
      #750000;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      logic [PAY_W-1:0] lin_cap, nl_cap;
      void'($urandom(32'd20240611));
      for (int i = 0; i < 32; i++) m[i] = '0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1: everything reads as integer zero after reset
      for (int i = 0; i < 32; i += 2) idle_read(5'(i), 5'(i + 1), "R1 reset");

      // R3: integer write drops upper bits, capability keeps them
      step(1'b1, 5'd3, 1'b0, {PAY_W{1'b1}}, 1'b0, 0, 0, 5'd0, 5'd0, "R3 int write");
      idle_read(5'd3, 5'd0, "R3 int masked");
      // R2: writes to register 0 vanish
      step(1'b1, 5'd0, 1'b1, {PAY_W{1'b1}}, 1'b0, 0, 0, 5'd3, 5'd3, "R2 zero write");
      idle_read(5'd0, 5'd3, "R2 zero reg");

      lin_cap = mkcap(2'd0, 3'd4, 64'h1000, 64'h1000, 64'h2000);
      nl_cap  = mkcap(2'd1, 3'd2, 64'h3008, 64'h3000, 64'h3100);
      step(1'b1, 5'd5, 1'b1, lin_cap, 1'b0, 0, 0, 5'd0, 5'd0, "R3 cap write");
      step(1'b1, 5'd6, 1'b1, nl_cap,  1'b0, 0, 0, 5'd5, 5'd0, "R3 cap write");
      idle_read(5'd5, 5'd6, "R3 cap readback");

      // R4: move from an integer register traps and changes nothing
      step(1'b0, 0, 0, '0, 1'b1, 5'd3, 5'd7, 5'd3, 5'd7, "R4 trap int src");
      step(1'b0, 0, 0, '0, 1'b1, 5'd0, 5'd8, 5'd7, 5'd8, "R4 trap zero src");
      idle_read(5'd7, 5'd8, "R4 no change");
      // R5: self move of linear cap keeps it
      step(1'b0, 0, 0, '0, 1'b1, 5'd5, 5'd5, 5'd5, 5'd0, "R5 self move");
      idle_read(5'd5, 5'd0, "R5 unchanged");
      // R6: non-linear copy keeps source
      step(1'b0, 0, 0, '0, 1'b1, 5'd6, 5'd8, 5'd6, 5'd8, "R6 nonlinear move");
      idle_read(5'd6, 5'd8, "R6 both hold");
      // R7: linear move nulls source
      step(1'b0, 0, 0, '0, 1'b1, 5'd5, 5'd9, 5'd5, 5'd9, "R7 linear move");
      idle_read(5'd5, 5'd9, "R7 source null");
      // R8: move wins over write to its destination and to its cleared source
      step(1'b1, 5'd10, 1'b0, 197'h55, 1'b1, 5'd9, 5'd10, 5'd9, 5'd10, "R8 dst conflict");
      idle_read(5'd10, 5'd9, "R8 move value kept");
      step(1'b1, 5'd10, 1'b0, 197'h66, 1'b1, 5'd10, 5'd11, 5'd10, 5'd11, "R8 src conflict");
      idle_read(5'd10, 5'd11, "R8 null kept");
      // R9: unrelated write proceeds alongside move and alongside trap
      step(1'b1, 5'd12, 1'b0, 197'h77, 1'b1, 5'd11, 5'd13, 5'd12, 5'd13, "R9 parallel");
      step(1'b1, 5'd14, 1'b1, nl_cap, 1'b1, 5'd12, 5'd15, 5'd12, 5'd13, "R9 with trap");
      idle_read(5'd14, 5'd15, "R9 results");
      // R2: move into register 0 is discarded but still nulls a linear source
      step(1'b0, 0, 0, '0, 1'b1, 5'd13, 5'd0, 5'd13, 5'd0, "R2 move to zero");
      idle_read(5'd0, 5'd13, "R2 zero after move");

      // R10 and all others: constrained random traffic on a dense register set
      for (int n = 0; n < 4000; n++) begin
         logic [PAY_W-1:0] d = rnd_pay();
         logic [4:0] wi = ($urandom % 8 == 0) ? 5'($urandom) : 5'($urandom % 12);
         logic [4:0] ms = 5'($urandom % 12);
         logic [4:0] md = ($urandom % 6 == 0) ? ms : 5'($urandom % 12);
         step(1'($urandom % 3 != 0), wi, 1'($urandom % 4 != 0), d,
              1'($urandom % 2), ms, md, 5'($urandom), 5'($urandom % 12),
              "R10 random");
      end

      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

endmodule